// File: doc/BRIEF.md
# Modem Handshake Status Register

This block watches the three active-low modem handshake inputs of a serial port: clear-to-send, data-set-ready and carrier-detect. It reports them to a host as one 32-bit status word. For each line the word holds the present state, active-high, and a sticky change flag. A change flag records that the line moved since the host last read the word. Each input passes through a synchronizer before it is compared, so asynchronous pins are safe to connect directly.

A companion control register supplies a loopback enable and the three modem control outputs (request-to-send, terminal-ready, auxiliary output 2). While loopback is on, those control values stand in for the pins. Switching loopback on or off is reported like any other line movement. The host reads through a plain strobe-and-address port. The read data is valid in the cycle of the strobe, and that read clears the change flags from the following cycle. Writes to the register are accepted and have no effect. There is no ring-indicator line, so its state bit and its change bit are always zero.

Top module: `modem_stat_reg`

## Requirements
- R1: Word layout. Bit 0 is the CTS change flag, bit 1 the DSR change flag and bit 3 the DCD change flag. Bit 4 is the CTS state, bit 5 the DSR state and bit 7 the DCD state. Bits 2 and 6 (ring indicator) always read 0.
- R2: Bits 31:8 of the word always read 0.
- R3: With loopback off, each state bit is the inverse of its active-low pin. A pin change driven just after a clock edge appears in the word after exactly three rising edges: two synchronizer stages and one state register.
- R4: A change flag is set whenever its line's effective state changes, in either direction. Several lines that change together each set their own flag.
- R5: A read is rd_en_i high, wr_en_i low and addr_i equal to 0x2C. It returns the current word in the same cycle and clears every change flag from the next cycle on.
- R6: If a line changes on the same clock edge that ends a clearing read, the read returns the old word and that line's flag is set afterwards.
- R7: With loop_en_i high, the CTS state follows rts_i, the DSR state follows dtr_i and the DCD state follows out2_i, one edge after each control change. Pin activity has no effect on the word while loopback is on.
- R8: Turning loopback on or off sets the change flag of every line whose effective state differs across the switch.
- R9: Outside a read, rd_data_o is 0. A strobe at another address, or any cycle with wr_en_i high, neither returns data nor clears flags.
- R10: Reset clears the state bits and the change flags. After reset is released, the state bits take up the synchronized pins during a settle window of three edges, and no change flag is set in that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_en_i | input | 1 | Loopback enable from the control register |
| rts_i | input | 1 | Request-to-send control bit, looped to CTS |
| dtr_i | input | 1 | Terminal-ready control bit, looped to DSR |
| out2_i | input | 1 | Auxiliary output 2 control bit, looped to DCD |
| addr_i | input | ADDR_W | Register byte address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe, ignored except that it blocks a read |
| rd_data_o | output | 32 | Status word during a read, 0 otherwise |

## Verification
The pins are swept first in binary count order, which often moves several lines at once, and then in Gray order, which moves a single line each step. Comparing the two shows whether each flag is wired to its own line or whether flags leak between lines. A back-to-back second read separates clear-on-read from flags that never clear. A read timed onto the third edge after a pin change checks the three-cycle latency and the rule that a new event wins over a clear. The loopback controls are swept through all eight values, with pin activity during loopback and transitions into and out of loopback. Separate sequences cover strobes at the wrong address, write cycles and a second reset with active pins, which exercise the ignore rules and the settle window.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_LINES = 3;

  // Line index order inside every internal vector: 0 = CTS, 1 = DSR, 2 = DCD.
  // Bit positions in the host word are decoded by driver software, so they are fixed.
  localparam int DELTA_POS [NUM_LINES] = '{0, 1, 3};
  localparam int STATE_POS [NUM_LINES] = '{4, 5, 7};

  function automatic logic [REG_W-1:0] pack_word(input logic [NUM_LINES-1:0] st,
                                                 input logic [NUM_LINES-1:0] dl);
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      w[DELTA_POS[i]] = dl[i];
      w[STATE_POS[i]] = st[i];
    end
    return w;
  endfunction
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {CHAIN_W{RST_VAL}};
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {CHAIN_W{RST_VAL}};
        else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/mstat_line.sv
module mstat_line (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync_n_i,
  input  logic loop_src_i,
  input  logic loop_en_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic eff_o,
  output logic state_o,
  output logic delta_o
);
  logic state_q;
  logic delta_q;
  logic eff;

  // Effective level: looped control bit, or the inverted synchronized pin.
  assign eff = loop_en_i ? loop_src_i : ~pin_sync_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      delta_q <= 1'b0;
    end else begin
      state_q <= eff;
      if (!arm_i) delta_q <= 1'b0;
      else        delta_q <= (eff != state_q) | (delta_q & ~clr_i);
    end
  end

  assign eff_o   = eff;
  assign state_o = state_q;
  assign delta_o = delta_q;
endmodule

// File: rtl/modem_stat_reg.sv
module modem_stat_reg
  import mstat_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET  = 8'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_n_i,
  input  logic              dsr_n_i,
  input  logic              dcd_n_i,
  input  logic              loop_en_i,
  input  logic              rts_i,
  input  logic              dtr_i,
  input  logic              out2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  output logic [REG_W-1:0]  rd_data_o
);
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(SETTLE + 1);

  logic [NUM_LINES-1:0] pin_n;
  logic [NUM_LINES-1:0] pin_sync_n;
  logic [NUM_LINES-1:0] loop_src;
  logic [NUM_LINES-1:0] line_eff;
  logic [NUM_LINES-1:0] line_state;
  logic [NUM_LINES-1:0] line_delta;
  logic [CNT_W-1:0]     settle_q;
  logic                 arm;
  logic                 rd_hit;

  assign pin_n    = {dcd_n_i, dsr_n_i, cts_n_i};
  assign loop_src = {out2_i, dtr_i, rts_i};

  mstat_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_n),
    .q_o  (pin_sync_n)
  );

  // Settle window: state tracks the pins, flags stay quiet until the chain is full.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        settle_q <= '0;
    else if (settle_q != CNT_W'(SETTLE)) settle_q <= settle_q + 1'b1;
  end
  assign arm = (settle_q == CNT_W'(SETTLE));

  assign rd_hit = rd_en_i & ~wr_en_i & (addr_i == REG_OFFSET);

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      mstat_line u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_sync_n_i(pin_sync_n[i]),
        .loop_src_i  (loop_src[i]),
        .loop_en_i   (loop_en_i),
        .arm_i       (arm),
        .clr_i       (rd_hit),
        .eff_o       (line_eff[i]),
        .state_o     (line_state[i]),
        .delta_o     (line_delta[i])
      );
    end
  endgenerate

  assign rd_data_o = rd_hit ? pack_word(line_state, line_delta) : '0;
endmodule

// File: rtl/mstat_chk.sv
module mstat_chk #(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h2C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              loop_en_i,
  input logic              rts_i,
  input logic              dtr_i,
  input logic              out2_i,
  input logic [31:0]       rd_data_o,
  input logic [2:0]        line_eff,
  input logic [2:0]        line_state,
  input logic [2:0]        line_delta,
  input logic              arm
);
  logic hit;
  assign hit = rd_en_i && !wr_en_i && (addr_i == REG_OFFSET);

  p_ring_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[2] == 1'b0) && (rd_data_o[6] == 1'b0));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[31:8] == 24'h0);

  p_delta_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && (line_eff != line_state)) |=>
      ((line_delta & $past(line_eff ^ line_state)) == $past(line_eff ^ line_state)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && hit && (line_eff == line_state)) |=> (line_delta == 3'b000));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !hit) |=> ((line_delta & $past(line_delta)) == $past(line_delta)));

  p_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && loop_en_i && $past(loop_en_i)) |-> (line_state == $past({out2_i, dtr_i, rts_i})));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rd_data_o == 32'h0));

  p_settle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |-> (line_delta == 3'b000));
endmodule

bind modem_stat_reg mstat_chk #(
  .ADDR_W    (ADDR_W),
  .REG_OFFSET(REG_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en_i   (rd_en_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .loop_en_i (loop_en_i),
  .rts_i     (rts_i),
  .dtr_i     (dtr_i),
  .out2_i    (out2_i),
  .rd_data_o (rd_data_o),
  .line_eff  (line_eff),
  .line_state(line_state),
  .line_delta(line_delta),
  .arm       (arm)
);

// File: tb/modem_stat_reg_bench.sv
module modem_stat_reg_bench;
  localparam logic [7:0] OFF = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pin_n;   // 0 = CTS, 1 = DSR, 2 = DCD (active low)
  logic [2:0]  ctrl;    // 0 = RTS, 1 = DTR, 2 = OUT2
  logic        loop_en;
  logic [7:0]  addr;
  logic        rd_en;
  logic        wr_en;
  logic [31:0] rd_data;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  modem_stat_reg u_modem_stat_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cts_n_i  (pin_n[0]),
    .dsr_n_i  (pin_n[1]),
    .dcd_n_i  (pin_n[2]),
    .loop_en_i(loop_en),
    .rts_i    (ctrl[0]),
    .dtr_i    (ctrl[1]),
    .out2_i   (ctrl[2]),
    .addr_i   (addr),
    .rd_en_i  (rd_en),
    .wr_en_i  (wr_en),
    .rd_data_o(rd_data)
  );

  // Word value from R1: flags weigh 1, 2, 8; states weigh 16, 32, 128.
  function automatic logic [31:0] exp_word(input logic [2:0] st, input logic [2:0] dl);
    return 32'(dl[0]) * 1 + 32'(dl[1]) * 2 + 32'(dl[2]) * 8 +
           32'(st[0]) * 16 + 32'(st[1]) * 32 + 32'(st[2]) * 128;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called just after a falling edge; returns at the next falling edge.
  task automatic do_read(input string req, input logic [31:0] exp);
    rd_en = 1'b1;
    addr  = OFF;
    #1;
    check(req, rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  logic [2:0] st;
  logic [2:0] ns;
  logic [2:0] p;

  initial begin
    pin_n = 3'b100; ctrl = 3'b000; loop_en = 1'b0;
    addr = 8'h00; rd_en = 1'b0; wr_en = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    do_read("R10 reset word", exp_word(3'b000, 3'b000));
    wait_n(4);
    st = 3'b011;
    do_read("R10 settled, no flags", exp_word(st, 3'b000));
    #1 check("R9 idle output", rd_data, 32'h0);
    @(negedge clk);

    // Binary then Gray pin sweeps (R3, R4, R5)
    for (int k = 0; k < 16; k++) begin
      p = (k < 8) ? 3'(k) : (3'(k) ^ (3'(k) >> 1));
      pin_n = p;
      wait_n(3);
      ns = ~p;
      do_read("R3 R4 state and flags", exp_word(ns, st ^ ns));
      do_read("R5 flags cleared", exp_word(ns, 3'b000));
      st = ns;
    end

    // Change lands on the edge that ends a read (R3 latency, R6)
    ns = st ^ 3'b101;
    pin_n = ~ns;
    wait_n(2);
    do_read("R3 R6 old word", exp_word(st, 3'b000));
    do_read("R6 flag kept", exp_word(ns, 3'b101));
    st = ns;
    do_read("R5 clear after R6", exp_word(st, 3'b000));

    // Ignored strobes (R9)
    ns = st ^ 3'b010;
    pin_n = ~ns;
    wait_n(3);
    addr = OFF ^ 8'h04; rd_en = 1'b1;
    #1 check("R9 other address", rd_data, 32'h0);
    @(negedge clk);
    addr = OFF; wr_en = 1'b1;
    #1 check("R9 read with write", rd_data, 32'h0);
    @(negedge clk);
    rd_en = 1'b0;
    #1 check("R9 write only", rd_data, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    do_read("R9 flag survived", exp_word(ns, 3'b010));
    st = ns;

    // Layout (R1, R2)
    pin_n = 3'b000;
    wait_n(3);
    ns = 3'b111;
    rd_en = 1'b1; addr = OFF;
    #1;
    check("R1 ring bits", rd_data & 32'h44, 32'h0);
    check("R2 upper bits", rd_data >> 8, 32'h0);
    check("R1 R4 full word", rd_data, exp_word(ns, st ^ ns));
    @(negedge clk);
    rd_en = 1'b0;
    st = ns;

    // Loopback sweep (R7, R8)
    loop_en = 1'b1;
    for (int c = 0; c < 8; c++) begin
      ctrl = 3'(c);
      wait_n(1);
      do_read("R7 R8 loop state", exp_word(3'(c), st ^ 3'(c)));
      st = 3'(c);
    end
    pin_n = 3'b111;
    wait_n(4);
    do_read("R7 pins ignored", exp_word(st, 3'b000));
    pin_n = 3'b010;
    wait_n(4);
    do_read("R7 pins ignored again", exp_word(st, 3'b000));
    loop_en = 1'b0;
    wait_n(1);
    ns = 3'b101;
    do_read("R8 leave loopback", exp_word(ns, st ^ ns));
    st = ns;

    // Second reset with active pins (R10)
    pin_n = 3'b001;
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(5);
    do_read("R10 settle after reset", exp_word(3'b110, 3'b000));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule